// File: doc/BRIEF.md
# Banked Nibble-Register Calendar Clock

This block is a real-time calendar core that software reaches through sixteen 4-bit registers on a 4-bit address. Seconds, minutes, hours, day of week, day of month, month and a two-digit year are kept as BCD digits. A base tick input is divided down to one step per second. A mode register chooses which of four banks sits behind the thirteen low addresses: the running time, a small configuration bank with hour format and leap phase, or one of two scratch nibble RAMs. A control register clears the sub-second divider.

Software stops the count by clearing the run bit in the mode register. It then reads or loads the time digit by digit, sets the run bit again and, if it needs a clean second boundary, clears the divider. Hours can be kept in 24-hour form or in 12-hour form with a PM flag. The day rollover follows the month length and a four-year leap phase counter.

Top module: `nibble_rtc`

## Requirements
- R1: After reset every time digit reads 0, except day ones and month ones, which read 1 (date 01, month 01). The mode register reads 0, the leap phase reads 0 and the hour format bit reads 1 (24-hour).
- R2: In bank 0 the time digits sit at addresses 0 to 12 in this order: seconds ones, seconds tens, minutes ones, minutes tens, hours ones, hours tens, day of week, day ones, day tens, month ones, month tens, year ones, year tens. A write stores the nibble as given, and a read returns it.
- R3: Address 13 is the mode register in every bank: bit 3 run, bit 2 alarm flag (stored only), bits 1:0 bank (0 time, 1 configuration, 2 RAM A, 3 RAM B). Addresses 14 and 15 read 0 in every bank.
- R4: With the run bit set, the seconds advance by one after every TICKS_PER_SEC base ticks. With the run bit clear, ticks are discarded: neither the digits nor the divider move.
- R5: Writing the control register (address 15) with bit 1 set clears the divider, so the next second comes a full TICKS_PER_SEC ticks later.
- R6: In 24-hour mode, seconds wrap 59 to 00, minutes wrap 59 to 00, hours wrap 23 to 00, and each wrap carries into the next field.
- R7: In 12-hour mode (format bit 0 at configuration address 10) hours run from 12 through 11. Bit 1 of the hours-tens digit is PM. The step from 11 to 12 toggles PM, and the step from 11 PM to 12 AM advances the day.
- R8: The day wraps to 01 after the last day of the month: 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when the leap phase (configuration address 11, bits 1:0) is 0 and 28 days otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00. Every year advance adds one to the leap phase, modulo 4.
- R10: Day of week counts 0 to 6 and advances, wrapping 6 to 0, on every day rollover.
- R11: A write to a time digit in the same cycle as a counting step stores the written value in that digit. The other digits still take their counted values.
- R12: RAM banks A and B each hold 13 independent nibbles at addresses 0 to 12 and do not alias the time digits. Unused configuration addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick enable, TICKS_PER_SEC per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data nibble for addr (combinational) |

## Verification
The bench aims at every rollover boundary in the counter chain: 59 seconds, 59 minutes, 23 hours, the 11 and 12 o'clock steps of 12-hour mode, the end of 30-, 31-, 28- and 29-day months, and December 31 of year 99. A wrong carry there would leave a field at an illegal value such as 60 or day 32, or would skip or repeat a day or a year. It also checks the leap phase step, since a design that failed to advance it would keep giving February the wrong length in later years. It drives a write and a step in the same cycle to catch a design whose counted value beats the write. It checks divider clearing and ticks arriving while stopped, because a design that queued those ticks would step early once the run bit was set again.

// File: rtl/nrtc_pkg.sv
package nrtc_pkg;

    localparam int NIB    = 4;
    localparam int DIGITS = 13;

    typedef enum logic [1:0] {
        BANK_TIME  = 2'b00,
        BANK_CFG   = 2'b01,
        BANK_RAM_A = 2'b10,
        BANK_RAM_B = 2'b11
    } bank_e;

    typedef struct packed {
        logic  run;
        logic  alarm_on;
        bank_e bank;
    } mode_t;

    localparam logic [3:0] A_SEC1  = 4'd0;
    localparam logic [3:0] A_SEC10 = 4'd1;
    localparam logic [3:0] A_MIN1  = 4'd2;
    localparam logic [3:0] A_MIN10 = 4'd3;
    localparam logic [3:0] A_HR1   = 4'd4;
    localparam logic [3:0] A_HR10  = 4'd5;
    localparam logic [3:0] A_DOW   = 4'd6;
    localparam logic [3:0] A_DAY1  = 4'd7;
    localparam logic [3:0] A_DAY10 = 4'd8;
    localparam logic [3:0] A_MON1  = 4'd9;
    localparam logic [3:0] A_MON10 = 4'd10;
    localparam logic [3:0] A_YR1   = 4'd11;
    localparam logic [3:0] A_YR10  = 4'd12;
    localparam logic [3:0] A_FMT   = 4'd10;
    localparam logic [3:0] A_LEAP  = 4'd11;
    localparam logic [3:0] A_MODE  = 4'd13;
    localparam logic [3:0] A_TEST  = 4'd14;
    localparam logic [3:0] A_CTRL  = 4'd15;

    // Two-digit BCD increment that restarts at 'first' once 'last' is reached.
    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v >= last)
            return first;
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of a BCD month, given the leap phase.
    function automatic logic [7:0] month_days(input logic [7:0] mon,
                                              input logic [1:0] leap);
        case (mon)
            8'h02:                      return (leap == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/nrtc_divider.sv
module nrtc_divider #(
    parameter int TICKS_PER_SEC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic clear,
    output logic step
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign step = run && tick && !clear && (cnt == LAST);

    // R4: a stopped divider holds its phase
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));
    // R5: clearing restarts the divider
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));
    // R4: phase stays inside the divide ratio
    a_r4_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/nrtc_calendar.sv
module nrtc_calendar
    import nrtc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step,
    input  logic                        wr_time,
    input  logic                        wr_cfg,
    input  logic [3:0]                  waddr,
    input  logic [NIB-1:0]              wdata,
    output logic [DIGITS-1:0][NIB-1:0]  dig,
    output logic                        fmt24,
    output logic [1:0]                  leap
);
    localparam logic [3:0] LAST_DIGIT = 4'(DIGITS - 1);

    logic [DIGITS-1:0][NIB-1:0] nxt;
    logic [1:0] leap_n;
    logic       fmt_n;
    logic [7:0] sec, mn, hr, day, mon, yr;
    logic [7:0] hr_n, h12, h12_n, dlen;
    logic       pm, pm_n;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        sec = {dig[A_SEC10], dig[A_SEC1]};
        mn  = {dig[A_MIN10], dig[A_MIN1]};
        hr  = {dig[A_HR10],  dig[A_HR1]};
        day = {dig[A_DAY10], dig[A_DAY1]};
        mon = {dig[A_MON10], dig[A_MON1]};
        yr  = {dig[A_YR10],  dig[A_YR1]};
        nxt    = dig;
        leap_n = leap;
        fmt_n  = fmt24;

        c_min = step  && (sec >= 8'h59);
        c_hr  = c_min && (mn  >= 8'h59);

        h12   = {3'b000, hr[4], hr[3:0]};
        pm    = hr[5];
        pm_n  = pm;
        h12_n = h12;
        if (fmt24) begin
            c_day = c_hr && (hr >= 8'h23);
            hr_n  = bcd_step(hr, 8'h23, 8'h00);
        end else begin
            c_day = c_hr && pm && (h12 == 8'h11);
            if (h12 == 8'h11) begin
                h12_n = 8'h12;
                pm_n  = !pm;
            end else begin
                h12_n = bcd_step(h12, 8'h12, 8'h01);
            end
            hr_n = {2'b00, pm_n, h12_n[4], h12_n[3:0]};
        end

        dlen  = month_days(mon, leap);
        c_mon = c_day && (day >= dlen);
        c_yr  = c_mon && (mon >= 8'h12);

        if (step)  {nxt[A_SEC10], nxt[A_SEC1]} = bcd_step(sec, 8'h59, 8'h00);
        if (c_min) {nxt[A_MIN10], nxt[A_MIN1]} = bcd_step(mn, 8'h59, 8'h00);
        if (c_hr)  {nxt[A_HR10],  nxt[A_HR1]}  = hr_n;
        if (c_day) begin
            {nxt[A_DAY10], nxt[A_DAY1]} = bcd_step(day, dlen, 8'h01);
            nxt[A_DOW] = (dig[A_DOW] >= 4'd6) ? 4'd0 : dig[A_DOW] + 4'd1;
        end
        if (c_mon) {nxt[A_MON10], nxt[A_MON1]} = bcd_step(mon, 8'h12, 8'h01);
        if (c_yr) begin
            {nxt[A_YR10], nxt[A_YR1]} = bcd_step(yr, 8'h99, 8'h00);
            leap_n = leap + 2'd1;
        end

        // a register write beats the counted value of the same digit
        if (wr_time && waddr <= LAST_DIGIT)
            nxt[waddr] = wdata;
        if (wr_cfg && waddr == A_FMT)
            fmt_n = wdata[0];
        if (wr_cfg && waddr == A_LEAP)
            leap_n = wdata[1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dig          <= '0;
            dig[A_DAY1]  <= 4'd1;
            dig[A_MON1]  <= 4'd1;
            fmt24        <= 1'b1;
            leap         <= 2'd0;
        end else begin
            dig   <= nxt;
            fmt24 <= fmt_n;
            leap  <= leap_n;
        end
    end

    // R4: without a step or a write the time is frozen
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_time && !wr_cfg) |=> ($stable(dig) && $stable(leap)));
    // R11: a written digit holds the written value next cycle
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_time && waddr <= LAST_DIGIT) |=> (dig[$past(waddr)] == $past(wdata)));
    // R6: seconds wrap from 59 to 00
    a_r6_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_time && dig[A_SEC10] == 4'd5 && dig[A_SEC1] == 4'd9)
        |=> (dig[A_SEC10] == 4'd0 && dig[A_SEC1] == 4'd0));
    // R9: a year advance moves the leap phase by one
    a_r9_leap_step: assert property (@(posedge clk) disable iff (rst)
        (c_yr && !wr_cfg) |=> (leap == $past(leap) + 2'd1));

endmodule

// File: rtl/nrtc_scratch.sv
module nrtc_scratch
    import nrtc_pkg::*;
#(
    parameter int WORDS = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [3:0]     addr,
    input  logic [NIB-1:0] wdata,
    output logic [NIB-1:0] rdata
);
    localparam logic [3:0] LAST = 4'(WORDS - 1);

    logic [WORDS-1:0][NIB-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst)
            mem <= '0;
        else if (we && addr <= LAST)
            mem[addr] <= wdata;
    end

    assign rdata = (addr <= LAST) ? mem[addr] : '0;

    // R12: a stored nibble is there on the next cycle
    a_r12_store: assert property (@(posedge clk) disable iff (rst)
        (we && addr <= LAST) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
    import nrtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 16,
    parameter int RAM_WORDS     = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic [3:0] rdata
);
    localparam logic [3:0] LAST_DIGIT = 4'(DIGITS - 1);
    localparam int         NBANKS_RAM = 2;

    mode_t                      mode;
    logic                       step, clear_div, wr_time, wr_cfg;
    logic [DIGITS-1:0][NIB-1:0] dig;
    logic                       fmt24;
    logic [1:0]                 leap;
    logic [NBANKS_RAM-1:0][NIB-1:0] ram_rd;

    always_ff @(posedge clk) begin
        if (rst)
            mode <= '0;
        else if (wr_en && addr == A_MODE)
            mode <= mode_t'(wdata);
    end

    assign clear_div = wr_en && (addr == A_CTRL) && wdata[1];
    assign wr_time   = wr_en && (mode.bank == BANK_TIME) && (addr <= LAST_DIGIT);
    assign wr_cfg    = wr_en && (mode.bank == BANK_CFG);

    nrtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk(clk), .rst(rst), .run(mode.run), .tick(tick),
        .clear(clear_div), .step(step)
    );

    nrtc_calendar u_cal (
        .clk(clk), .rst(rst), .step(step), .wr_time(wr_time), .wr_cfg(wr_cfg),
        .waddr(addr), .wdata(wdata), .dig(dig), .fmt24(fmt24), .leap(leap)
    );

    for (genvar g = 0; g < NBANKS_RAM; g++) begin : g_ram
        nrtc_scratch #(.WORDS(RAM_WORDS)) u_ram (
            .clk(clk), .rst(rst),
            .we(wr_en && (mode.bank == bank_e'(g + 2))),
            .addr(addr), .wdata(wdata), .rdata(ram_rd[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MODE)
            rdata = mode;
        else if (addr == A_TEST || addr == A_CTRL)
            rdata = '0;
        else begin
            case (mode.bank)
                BANK_TIME:  rdata = (addr <= LAST_DIGIT) ? dig[addr] : '0;
                BANK_CFG:   rdata = (addr == A_FMT)  ? {3'b000, fmt24} :
                                    (addr == A_LEAP) ? {2'b00, leap} : '0;
                BANK_RAM_A: rdata = ram_rd[0];
                default:    rdata = ram_rd[1];
            endcase
        end
    end

    // R3: mode register visible at its address in every bank
    a_r3_mode_visible: assert property (@(posedge clk) disable iff (rst)
        (addr == A_MODE) |-> (rdata == mode));
    // R3: test and control addresses read as zero
    a_r3_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == A_TEST || addr == A_CTRL) |-> (rdata == 4'd0));
    // R4: no step while stopped
    a_r4_no_step_stopped: assert property (@(posedge clk) disable iff (rst)
        !mode.run |-> !step);

endmodule

// File: tb/nibble_rtc_tb_top.sv
module nibble_rtc_tb_top;
    localparam int TPS = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick, wr_en;
    logic [3:0] addr, wdata;
    logic [3:0] rdata;

    int checks = 0;
    int fails  = 0;

    int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_dow, m_leap;
    bit m_24;

    always #5 clk = ~clk;

    nibble_rtc #(.TICKS_PER_SEC(TPS), .RAM_WORDS(13)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int mdays(input int mo, input int lp);
        if (mo == 2) return (lp == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] enc();
        logic [55:0] e;
        int h, t;
        e = '0;
        e[0*4 +: 4]  = 4'(m_sec % 10);  e[1*4 +: 4]  = 4'(m_sec / 10);
        e[2*4 +: 4]  = 4'(m_min % 10);  e[3*4 +: 4]  = 4'(m_min / 10);
        if (m_24) begin
            e[4*4 +: 4] = 4'(m_hr % 10); e[5*4 +: 4] = 4'(m_hr / 10);
        end else begin
            h = (m_hr % 12 == 0) ? 12 : m_hr % 12;
            t = h / 10 + ((m_hr >= 12) ? 2 : 0);
            e[4*4 +: 4] = 4'(h % 10); e[5*4 +: 4] = 4'(t);
        end
        e[6*4 +: 4]  = 4'(m_dow);
        e[7*4 +: 4]  = 4'(m_day % 10);  e[8*4 +: 4]  = 4'(m_day / 10);
        e[9*4 +: 4]  = 4'(m_mon % 10);  e[10*4 +: 4] = 4'(m_mon / 10);
        e[11*4 +: 4] = 4'(m_yr % 10);   e[12*4 +: 4] = 4'(m_yr / 10);
        e[55:52]     = 4'(m_leap);
        return e;
    endfunction

    task automatic advance();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0;
            m_dow = (m_dow + 1) % 7;
            m_day++;
            if (m_day > mdays(m_mon, m_leap)) begin
                m_day = 1; m_mon++;
                if (m_mon == 13) begin
                    m_mon = 1; m_yr = (m_yr + 1) % 100; m_leap = (m_leap + 1) % 4;
                end
            end
        end
    endtask

    task automatic setm(input int s, input int mi, input int h, input int d,
                        input int mo, input int y, input int dw, input int lp,
                        input bit f24);
        m_sec = s; m_min = mi; m_hr = h; m_day = d; m_mon = mo;
        m_yr = y; m_dow = dw; m_leap = lp; m_24 = f24;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // load model into the design, leave it running with a cleared divider
    task automatic load();
        logic [55:0] e;
        e = enc();
        wr(4'd13, 4'h0);
        for (int i = 0; i < 13; i++) wr(4'(i), e[i*4 +: 4]);
        wr(4'd13, 4'h1);
        wr(4'd10, {3'b000, m_24});
        wr(4'd11, e[55:52]);
        wr(4'd13, 4'h8);
        wr(4'd15, 4'h2);
    endtask

    // stops the count, returns {leap, digits}
    task automatic readall(output logic [55:0] got);
        logic [3:0] d;
        got = '0;
        wr(4'd13, 4'h0);
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), d);
            got[i*4 +: 4] = d;
        end
        wr(4'd13, 4'h1);
        rd(4'd11, d);
        got[55:52] = d;
        wr(4'd13, 4'h0);
    endtask

    task automatic step_check(input string req);
        logic [55:0] got;
        load();
        ticks(TPS);
        advance();
        readall(got);
        chk(got == enc(), req, 64'(got), 64'(enc()));
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [55:0] got, exp;
        logic [3:0]  d;
        void'($urandom(32'd715));
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd13, d);
        chk(d == 4'h0, "R1 mode", 64'(d), 64'h0);
        setm(0, 0, 0, 1, 1, 0, 0, 0, 1'b1);
        readall(got);
        chk(got == enc(), "R1 time", 64'(got), 64'(enc()));
        wr(4'd13, 4'h1);
        rd(4'd10, d);
        chk(d == 4'h1, "R1 format", 64'(d), 64'h1);
        // R12 unused configuration address reads zero
        rd(4'd0, d);
        chk(d == 4'h0, "R12 cfg unused", 64'(d), 64'h0);

        // R3 mode register, test and control
        wr(4'd13, 4'h7);
        rd(4'd13, d);
        chk(d == 4'h7, "R3 mode readback", 64'(d), 64'h7);
        rd(4'd14, d);
        chk(d == 4'h0, "R3 test reads 0", 64'(d), 64'h0);
        rd(4'd15, d);
        chk(d == 4'h0, "R3 ctrl reads 0", 64'(d), 64'h0);

        // R12 scratch banks
        wr(4'd13, 4'h2);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'((i + 5) & 15));
        wr(4'd13, 4'h3);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'(~i & 15));
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), d);
            chk(d == 4'(~i & 15), "R12 RAM B", 64'(d), 64'(~i & 15));
        end
        wr(4'd13, 4'h2);
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), d);
            chk(d == 4'((i + 5) & 15), "R12 RAM A", 64'(d), 64'((i + 5) & 15));
        end
        wr(4'd13, 4'h0);
        rd(4'd0, d);
        chk(d == 4'h0, "R12 time untouched", 64'(d), 64'h0);

        // R2 raw digit storage
        for (int i = 0; i < 13; i++) wr(4'(i), 4'((i * 7 + 3) & 15));
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), d);
            chk(d == 4'((i * 7 + 3) & 15), "R2 digit", 64'(d), 64'((i * 7 + 3) & 15));
        end

        // R4 stopped ticks discarded, divide ratio
        setm(10, 20, 5, 3, 3, 21, 2, 1, 1'b1);
        load();
        wr(4'd13, 4'h0);
        ticks(3 * TPS + 5);
        wr(4'd13, 4'h8);
        ticks(TPS - 1);
        readall(got);
        chk(got == enc(), "R4 no step early", 64'(got), 64'(enc()));
        wr(4'd13, 4'h8);
        ticks(1);
        advance();
        readall(got);
        chk(got == enc(), "R4 step after ratio", 64'(got), 64'(enc()));

        // R5 divider clear
        load();
        ticks(TPS - 1);
        wr(4'd15, 4'h2);
        ticks(TPS - 1);
        readall(got);
        chk(got == enc(), "R5 cleared divider", 64'(got), 64'(enc()));
        wr(4'd13, 4'h8);
        ticks(1);
        advance();
        readall(got);
        chk(got == enc(), "R5 full second", 64'(got), 64'(enc()));

        // R11 write beats same-cycle step
        setm(59, 0, 10, 5, 6, 30, 1, 2, 1'b1);
        load();
        ticks(TPS - 1);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 4'd3;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        advance();
        exp = enc();
        exp[3:0] = 4'd3;
        readall(got);
        chk(got == exp, "R11 write priority", 64'(got), 64'(exp));

        // R6 directed 24-hour rollover
        setm(59, 59, 23, 14, 7, 45, 6, 1, 1'b1);
        step_check("R6 R10 midnight");
        // R7 12-hour cases
        setm(59, 59, 11, 9, 8, 12, 3, 0, 1'b0);
        step_check("R7 noon PM toggle");
        setm(59, 59, 12, 9, 8, 12, 3, 0, 1'b0);
        step_check("R7 12 to 1 PM");
        setm(59, 59, 23, 9, 8, 12, 3, 0, 1'b0);
        step_check("R7 midnight day advance");
        setm(59, 59, 0, 9, 8, 12, 3, 0, 1'b0);
        step_check("R7 12 to 1 AM");
        // R8 month lengths
        setm(59, 59, 23, 30, 4, 10, 0, 1, 1'b1);
        step_check("R8 30-day month");
        setm(59, 59, 23, 30, 5, 10, 0, 1, 1'b1);
        step_check("R8 31-day month");
        setm(59, 59, 23, 28, 2, 10, 0, 0, 1'b1);
        step_check("R8 leap February 29");
        setm(59, 59, 23, 29, 2, 10, 0, 0, 1'b1);
        step_check("R8 leap February end");
        setm(59, 59, 23, 28, 2, 10, 0, 2, 1'b1);
        step_check("R8 plain February end");
        // R9 year and century wrap
        setm(59, 59, 23, 31, 12, 99, 6, 3, 1'b1);
        step_check("R9 year 99 wrap");
        setm(59, 59, 23, 31, 12, 41, 4, 1, 1'b1);
        step_check("R9 leap phase step");

        // random near-rollover times: R6 R7 R8 R9 R10
        for (int it = 0; it < 40; it++) begin
            int mo, pick;
            mo = 1 + int'($urandom % 12);
            m_leap = int'($urandom % 4);
            m_24 = bit'($urandom % 2);
            m_mon = mo;
            m_day = ($urandom % 2 == 0) ? mdays(mo, m_leap)
                                        : 1 + int'($urandom % mdays(mo, m_leap));
            m_sec = ($urandom % 4 == 0) ? int'($urandom % 60) : 59;
            m_min = ($urandom % 4 == 0) ? int'($urandom % 60) : 59;
            pick = int'($urandom % 5);
            m_hr = (pick == 0) ? 23 : (pick == 1) ? 11 : (pick == 2) ? 12 :
                   (pick == 3) ? 0 : int'($urandom % 24);
            m_yr = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
            if (m_mon == 12 && $urandom % 2 == 0) m_day = 31;
            m_dow = int'($urandom % 7);
            step_check("R6 R7 R8 R9 R10 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule